// File: doc/BRIEF.md
# Clustered Fetch-Line Branch Target Buffer

This block predicts, for one fetch line, where control flow leaves the line. The fetch address is broken into three fields: a byte offset within the line, a set index and a tag. Every way of the addressed set that holds a valid branch with the right tag is a candidate. Candidates that sit at an offset smaller than the fetch offset lie behind the fetch point and are ignored. Among the rest, the branch with the lowest offset that is predicted taken wins, and its target is returned. When no branch wins, the block points at the next sequential line.

Direction for conditional branches comes from a two-level scheme. Each entry keeps a short local history, and that history selects one of a per-set table of 2-bit counters. The history is advanced with the predicted outcome when a lookup is made. A later update then repairs the newest history bit with the resolved outcome and trains the counter that made the prediction. The same update port allocates a new entry when the branch is not yet present.

A two-state controller governs the block. In `ST_INIT`, entered at reset, one set per cycle is cleared and its counters are primed. The transition `INIT_DONE` is taken once the last set has been cleared. In `ST_RUN` lookups and updates are served; that state has only the self-loop `RUN_HOLD` and is left only by reset.

Top module: `btb_cluster`

## Requirements
- R1: After reset `ready` stays low for exactly 128 rising edges (one per set) and then stays high. While `ready` is low, fetches give no `pred_valid` and updates are dropped. Every entry ends up invalid, every replacement pointer at way 0 and every counter at 2'b01.
- R2: A fetch presented with `fetch_valid` high while `ready` is high yields `pred_valid` high on the next rising edge, with the prediction fields registered at that same edge.
- R3: Address fields are the offset `ip[3:0]`, the set `ip[10:4]` and the tag `ip[31:11]`.
- R4: A way is eligible when it is valid, its tag equals the fetch tag and its stored offset is greater than or equal to the fetch offset. `pred_hit` is high when any way is eligible.
- R5: Among eligible ways that are predicted taken, the one with the lowest stored offset is selected. `pred_taken` is high and `pred_target`, `pred_kind` and `pred_offset` are that way's target, kind and offset.
- R6: Kind encoding is 2'b00 conditional, 2'b01 return, 2'b10 call and 2'b11 unconditional. Non-conditional kinds are always predicted taken. A conditional branch is predicted taken when bit 1 of the set's counter indexed by the entry's 4-bit history is set.
- R7: When no eligible way is predicted taken, `pred_taken` is low, `pred_target` is `{ip[31:4]+1, 4'h0}` (wrapping at the top of the address space), and `pred_kind` and `pred_offset` are zero.
- R8: On each accepted fetch, every eligible way whose offset is not beyond the selected one (all eligible ways when none is taken) shifts its predicted outcome into bit 0 of its history. The bit leaving history bit 3 is saved in that entry.
- R9: An update whose address matches a valid entry (same tag, set and offset) trains the set counter at index {saved bit, history[3:1]}: plus one when taken, minus one when not taken. The entry's history bit 0 is replaced by the resolved outcome, and its kind and target are overwritten.
- R10: An update that matches no entry allocates the way named by the set's replacement pointer. The new entry has history zero and saved bit zero, and the pointer then advances by one modulo 4.
- R11: Counters saturate at 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | output | 1 | High once the set-clearing sweep has finished |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_ip | input | 32 | Fetch address of the lookup |
| pred_valid | output | 1 | Prediction fields below belong to the previous cycle's lookup |
| pred_hit | output | 1 | At least one eligible branch was found |
| pred_taken | output | 1 | A branch in the line is predicted taken |
| pred_target | output | 32 | Taken target, or next sequential line address |
| pred_kind | output | 2 | Kind of the selected branch |
| pred_offset | output | 4 | Line offset of the selected branch |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_ip | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_kind | input | 2 | Kind of the resolved branch |
| upd_target | input | 32 | Resolved target |

## Verification
The assertions assume that each `pred_valid` refers to the fetch address presented one edge earlier. They also assume that the caller uses the update port only for branches whose history was advanced by at most one lookup since the previous update. The stimulus never presents a fetch and an update in the same cycle, so the expected history is never in doubt. It draws tags and sets from small pools, so several ways of one set match the same tag and replacement wraps often. Both directed and random sequences keep training one branch without intervening lookups, which drives the counters into both saturation limits.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        BR_COND = 2'b00,
        BR_RET  = 2'b01,
        BR_CALL = 2'b10,
        BR_JMP  = 2'b11
    } br_kind_e;

    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } btb_state_e;

endpackage

// File: rtl/btb_way_eval.sv
module btb_way_eval #(
    parameter int OFS_W = 4,
    parameter int TAG_W = 21
) (
    input  logic             e_vld,
    input  logic [TAG_W-1:0] e_tag,
    input  logic [OFS_W-1:0] e_ofs,
    input  logic [1:0]       e_kind,
    input  logic             cnt_msb,
    input  logic [TAG_W-1:0] f_tag,
    input  logic [OFS_W-1:0] f_ofs,
    output logic             eligible,
    output logic             taken
);
    import btb_pkg::*;

    always_comb begin
        eligible = e_vld && (e_tag == f_tag) && (e_ofs >= f_ofs);
        taken    = (e_kind != BR_COND) || cnt_msb;
    end

endmodule

// File: rtl/btb_first_taken.sv
module btb_first_taken #(
    parameter int WAYS  = 4,
    parameter int OFS_W = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            elig,
    input  logic [WAYS-1:0]            taken,
    input  logic [WAYS-1:0][OFS_W-1:0] ofs,
    output logic                       any_hit,
    output logic                       any_taken,
    output logic [WAY_W-1:0]           sel,
    output logic [OFS_W-1:0]           sel_ofs
);
    always_comb begin
        any_hit   = 1'b0;
        any_taken = 1'b0;
        sel       = '0;
        sel_ofs   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (elig[w]) any_hit = 1'b1;
            if (elig[w] && taken[w] && (!any_taken || ofs[w] < sel_ofs)) begin
                any_taken = 1'b1;
                sel       = WAY_W'(w);
                sel_ofs   = ofs[w];
            end
        end
    end

endmodule

// File: rtl/btb_cluster.sv
module btb_cluster #(
    parameter int IP_W   = 32,
    parameter int OFS_W  = 4,
    parameter int SET_W  = 7,
    parameter int WAYS   = 4,
    parameter int HIST_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            ready,
    input  logic            fetch_valid,
    input  logic [IP_W-1:0] fetch_ip,
    output logic            pred_valid,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [IP_W-1:0] pred_target,
    output logic [1:0]      pred_kind,
    output logic [OFS_W-1:0] pred_offset,
    input  logic            upd_valid,
    input  logic [IP_W-1:0] upd_ip,
    input  logic            upd_taken,
    input  logic [1:0]      upd_kind,
    input  logic [IP_W-1:0] upd_target
);
    import btb_pkg::*;

    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = IP_W - OFS_W - SET_W;
    localparam int CNTS  = 1 << HIST_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LINE_W = IP_W - OFS_W;

    // storage
    logic              e_vld  [SETS][WAYS];
    logic [TAG_W-1:0]  e_tag  [SETS][WAYS];
    logic [OFS_W-1:0]  e_ofs  [SETS][WAYS];
    logic [1:0]        e_kind [SETS][WAYS];
    logic [HIST_W-1:0] e_hist [SETS][WAYS];
    logic              e_top  [SETS][WAYS];
    logic [IP_W-1:0]   e_tgt  [SETS][WAYS];
    logic [WAY_W-1:0]  repl   [SETS];
    logic [1:0]        cnt    [SETS][CNTS];

    btb_state_e       state, state_nx;
    logic [SET_W-1:0] init_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_INIT;
            init_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_INIT) init_idx <= init_idx + 1'b1;
        end
    end

    // transitions: INIT_DONE and RUN_HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT: if (init_idx == SET_W'(SETS - 1)) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    assign ready = (state == ST_RUN);

    // lookup side
    logic [OFS_W-1:0] f_ofs;
    logic [SET_W-1:0] f_set;
    logic [TAG_W-1:0] f_tag;
    assign f_ofs = fetch_ip[OFS_W-1:0];
    assign f_set = fetch_ip[OFS_W +: SET_W];
    assign f_tag = fetch_ip[IP_W-1 -: TAG_W];

    logic [WAYS-1:0]            w_elig, w_taken;
    logic [WAYS-1:0][OFS_W-1:0] w_ofs;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign w_ofs[w] = e_ofs[f_set][w];
        btb_way_eval #(.OFS_W(OFS_W), .TAG_W(TAG_W)) u_eval (
            .e_vld    (e_vld[f_set][w]),
            .e_tag    (e_tag[f_set][w]),
            .e_ofs    (e_ofs[f_set][w]),
            .e_kind   (e_kind[f_set][w]),
            .cnt_msb  (cnt[f_set][e_hist[f_set][w]][1]),
            .f_tag    (f_tag),
            .f_ofs    (f_ofs),
            .eligible (w_elig[w]),
            .taken    (w_taken[w])
        );
    end

    logic             any_hit, any_taken;
    logic [WAY_W-1:0] sel;
    logic [OFS_W-1:0] sel_ofs;

    btb_first_taken #(.WAYS(WAYS), .OFS_W(OFS_W)) u_pick (
        .elig      (w_elig),
        .taken     (w_taken),
        .ofs       (w_ofs),
        .any_hit   (any_hit),
        .any_taken (any_taken),
        .sel       (sel),
        .sel_ofs   (sel_ofs)
    );

    logic [IP_W-1:0] next_line;
    assign next_line = {fetch_ip[IP_W-1:OFS_W] + LINE_W'(1), {OFS_W{1'b0}}};

    // update side
    logic [OFS_W-1:0]  u_ofs;
    logic [SET_W-1:0]  u_set;
    logic [TAG_W-1:0]  u_tag;
    logic              u_hit;
    logic [WAY_W-1:0]  u_way;
    logic [HIST_W-1:0] u_prior;
    logic [1:0]        u_cnt_old, u_cnt_new;
    assign u_ofs = upd_ip[OFS_W-1:0];
    assign u_set = upd_ip[OFS_W +: SET_W];
    assign u_tag = upd_ip[IP_W-1 -: TAG_W];

    always_comb begin
        u_hit = 1'b0;
        u_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (e_vld[u_set][w] && e_tag[u_set][w] == u_tag && e_ofs[u_set][w] == u_ofs) begin
                u_hit = 1'b1;
                u_way = WAY_W'(w);
            end
        end
        u_prior   = {e_top[u_set][u_way], e_hist[u_set][u_way][HIST_W-1:1]};
        u_cnt_old = cnt[u_set][u_prior];
        if (upd_taken) u_cnt_new = (u_cnt_old == 2'b11) ? u_cnt_old : u_cnt_old + 2'd1;
        else           u_cnt_new = (u_cnt_old == 2'b00) ? u_cnt_old : u_cnt_old - 2'd1;
    end

    // storage writes
    always_ff @(posedge clk) begin
        if (state == ST_INIT) begin
            for (int w = 0; w < WAYS; w++) e_vld[init_idx][w] <= 1'b0;
            for (int c = 0; c < CNTS; c++) cnt[init_idx][c] <= 2'b01;
            repl[init_idx] <= '0;
        end else begin
            if (fetch_valid) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (w_elig[w] && (!any_taken || w_ofs[w] <= sel_ofs)) begin
                        e_hist[f_set][w] <= {e_hist[f_set][w][HIST_W-2:0], w_taken[w]};
                        e_top[f_set][w]  <= e_hist[f_set][w][HIST_W-1];
                    end
                end
            end
            if (upd_valid) begin
                if (u_hit) begin
                    cnt[u_set][u_prior]     <= u_cnt_new;
                    e_hist[u_set][u_way]    <= {e_hist[u_set][u_way][HIST_W-1:1], upd_taken};
                    e_kind[u_set][u_way]    <= upd_kind;
                    e_tgt[u_set][u_way]     <= upd_target;
                end else begin
                    e_vld[u_set][repl[u_set]]  <= 1'b1;
                    e_tag[u_set][repl[u_set]]  <= u_tag;
                    e_ofs[u_set][repl[u_set]]  <= u_ofs;
                    e_kind[u_set][repl[u_set]] <= upd_kind;
                    e_tgt[u_set][repl[u_set]]  <= upd_target;
                    e_hist[u_set][repl[u_set]] <= '0;
                    e_top[u_set][repl[u_set]]  <= 1'b0;
                    repl[u_set]                <= repl[u_set] + 1'b1;
                end
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_valid  <= 1'b0;
            pred_hit    <= 1'b0;
            pred_taken  <= 1'b0;
            pred_target <= '0;
            pred_kind   <= '0;
            pred_offset <= '0;
        end else begin
            pred_valid <= fetch_valid && (state == ST_RUN);
            if (fetch_valid && state == ST_RUN) begin
                pred_hit   <= any_hit;
                pred_taken <= any_taken;
                if (any_taken) begin
                    pred_target <= e_tgt[f_set][sel];
                    pred_kind   <= e_kind[f_set][sel];
                    pred_offset <= sel_ofs;
                end else begin
                    pred_target <= next_line;
                    pred_kind   <= BR_COND;
                    pred_offset <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/btb_cluster_chk.sv
module btb_cluster_chk #(
    parameter int IP_W  = 32,
    parameter int OFS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             fetch_valid,
    input logic [IP_W-1:0]  fetch_ip,
    input logic             pred_valid,
    input logic             pred_hit,
    input logic             pred_taken,
    input logic [IP_W-1:0]  pred_target,
    input logic [1:0]       pred_kind,
    input logic [OFS_W-1:0] pred_offset
);
    localparam int LINE_W = IP_W - OFS_W;

    a_r1_quiet_init: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !pred_valid);

    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fetch_valid) |=> pred_valid);

    a_r4_taken_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_taken) |-> pred_hit);

    a_r5_offset_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_taken) |-> (pred_offset >= $past(fetch_ip[OFS_W-1:0])));

    a_r7_next_line: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !pred_taken) |->
            (pred_target == {$past(fetch_ip[IP_W-1:OFS_W]) + LINE_W'(1), {OFS_W{1'b0}}})
            && pred_kind == 2'b00 && pred_offset == '0);

endmodule

bind btb_cluster btb_cluster_chk #(.IP_W(IP_W), .OFS_W(OFS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .fetch_valid (fetch_valid),
    .fetch_ip    (fetch_ip),
    .pred_valid  (pred_valid),
    .pred_hit    (pred_hit),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .pred_kind   (pred_kind),
    .pred_offset (pred_offset)
);

// File: tb/btb_cluster_test.sv
`timescale 1ns/1ps
module btb_cluster_test;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_ip = '0;
    logic        pred_valid, pred_hit, pred_taken;
    logic [31:0] pred_target;
    logic [1:0]  pred_kind;
    logic [3:0]  pred_offset;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_ip = '0;
    logic        upd_taken = 1'b0;
    logic [1:0]  upd_kind = '0;
    logic [31:0] upd_target = '0;

    always #(HALF) clk = ~clk;

    btb_cluster uut (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .fetch_valid(fetch_valid), .fetch_ip(fetch_ip),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
        .pred_target(pred_target), .pred_kind(pred_kind), .pred_offset(pred_offset),
        .upd_valid(upd_valid), .upd_ip(upd_ip), .upd_taken(upd_taken),
        .upd_kind(upd_kind), .upd_target(upd_target)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference state, built from the requirements
    bit        m_vld  [128][4];
    bit [20:0] m_tag  [128][4];
    bit [3:0]  m_ofs  [128][4];
    bit [1:0]  m_kind [128][4];
    bit [3:0]  m_hist [128][4];
    bit        m_top  [128][4];
    bit [31:0] m_tgt  [128][4];
    bit [1:0]  m_ptr  [128];
    bit [1:0]  m_cnt  [128][16];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 128; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
            for (int c = 0; c < 16; c++) m_cnt[s][c] = 2'b01;
        end
    endtask

    // expected prediction, then speculative history shift
    function automatic logic [39:0] model_fetch(input logic [31:0] ip);
        bit [3:0] fo = ip[3:0];
        int s = ip[10:4];
        bit [20:0] t = ip[31:11];
        bit el[4];
        bit pr[4];
        bit hit = 0, tk = 0;
        int bw = 0;
        bit [3:0] bo = 0;
        logic [31:0] tgt;
        logic [1:0] kd;
        for (int w = 0; w < 4; w++) begin
            el[w] = m_vld[s][w] && m_tag[s][w] == t && m_ofs[s][w] >= fo;
            pr[w] = (m_kind[s][w] != 2'b00) || m_cnt[s][m_hist[s][w]][1];
            if (el[w]) hit = 1;
            if (el[w] && pr[w] && (!tk || m_ofs[s][w] < bo)) begin
                tk = 1; bw = w; bo = m_ofs[s][w];
            end
        end
        if (tk) begin tgt = m_tgt[s][bw]; kd = m_kind[s][bw]; end
        else begin tgt = {ip[31:4] + 28'd1, 4'h0}; kd = 0; bo = 0; end
        for (int w = 0; w < 4; w++) begin
            if (el[w] && (!tk || m_ofs[s][w] <= bo)) begin
                m_top[s][w]  = m_hist[s][w][3];
                m_hist[s][w] = {m_hist[s][w][2:0], pr[w]};
            end
        end
        return {hit, tk, kd, bo, tgt};
    endfunction

    task automatic model_update(input logic [31:0] ip, input bit tk, input logic [1:0] kd, input logic [31:0] tg);
        int s = ip[10:4];
        int hw = -1;
        for (int w = 3; w >= 0; w--)
            if (m_vld[s][w] && m_tag[s][w] == ip[31:11] && m_ofs[s][w] == ip[3:0]) hw = w;
        if (hw >= 0) begin
            bit [3:0] idx = {m_top[s][hw], m_hist[s][hw][3:1]};
            if (tk && m_cnt[s][idx] != 3) m_cnt[s][idx]++;
            if (!tk && m_cnt[s][idx] != 0) m_cnt[s][idx]--;
            m_hist[s][hw] = {m_hist[s][hw][3:1], tk};
            m_kind[s][hw] = kd;
            m_tgt[s][hw]  = tg;
        end else begin
            int p = m_ptr[s];
            m_vld[s][p] = 1; m_tag[s][p] = ip[31:11]; m_ofs[s][p] = ip[3:0];
            m_kind[s][p] = kd; m_tgt[s][p] = tg; m_hist[s][p] = 0; m_top[s][p] = 0;
            m_ptr[s] = m_ptr[s] + 2'd1;
        end
    endtask

    task automatic do_fetch(input logic [31:0] ip, input string req);
        logic [39:0] exp = model_fetch(ip);
        logic [39:0] act;
        fetch_valid = 1'b1;
        fetch_ip = ip;
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        act = {pred_hit, pred_taken, pred_kind, pred_offset, pred_target};
        check(pred_valid === 1'b1 && act === exp, req, {23'd0, pred_valid, act}, {24'd1, exp});
    endtask

    task automatic do_update(input logic [31:0] ip, input bit tk, input logic [1:0] kd, input logic [31:0] tg);
        model_update(ip, tk, kd, tg);
        upd_valid = 1'b1; upd_ip = ip; upd_taken = tk; upd_kind = kd; upd_target = tg;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk_ip(input logic [20:0] t, input int s, input logic [3:0] o);
        return {t, 7'(s), o};
    endfunction

    // watchdog
    initial begin
        #(2 * HALF * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        logic [20:0] tags [3];
        int sets [4];
        tags[0] = 21'h0ABCD; tags[1] = 21'h1F00F; tags[2] = 21'h00001;
        sets[0] = 3; sets[1] = 5; sets[2] = 127; sets[3] = 64;
        void'($urandom(32'd20240611));
        model_reset();

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(ready === 1'b0, "R1 ready low after reset", {63'd0, ready}, 64'd0);

        // R1: fetch during the sweep is not answered
        fetch_valid = 1'b1; fetch_ip = 32'h0000_0050;
        n = 0;
        while (n < 200) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 1) begin
                check(pred_valid === 1'b0, "R1 no prediction during init", {63'd0, pred_valid}, 64'd0);
                fetch_valid = 1'b0;
            end
            if (ready === 1'b1) break;
        end
        check(n == 128, "R1 sweep length", 64'(n), 64'd128);

        // R7 R3: empty table, next-line with wrap
        do_fetch(mk_ip(tags[0], 5, 4'h3), "R7 R3 miss gives next line");
        do_fetch(32'hFFFF_FFF5, "R7 next line wraps");

        // R6 R5 R4: unconditional at offset 8
        do_update(mk_ip(tags[0], 5, 4'h8), 1, 2'b11, 32'h1234_5678);
        do_fetch(mk_ip(tags[0], 5, 4'h3), "R6 R5 unconditional taken");
        do_fetch(mk_ip(tags[0], 5, 4'h9), "R4 way behind fetch offset ignored");
        do_fetch(mk_ip(tags[0], 5, 4'h8), "R4 equal offset eligible");
        do_fetch(mk_ip(tags[1], 5, 4'h0), "R3 R4 other tag misses");

        // R5: not-taken conditional before a taken branch
        do_update(mk_ip(tags[0], 5, 4'h4), 0, 2'b00, 32'hAAAA_0000);
        do_fetch(mk_ip(tags[0], 5, 4'h0), "R5 R8 skip weak conditional");
        do_update(mk_ip(tags[0], 5, 4'h2), 1, 2'b01, 32'hBBBB_0000);
        do_fetch(mk_ip(tags[0], 5, 4'h0), "R5 R6 return taken lowest offset");
        do_fetch(mk_ip(tags[0], 5, 4'h3), "R5 later ways selected");

        // R11: saturation high, observed through one decrement
        do_update(mk_ip(tags[2], 3, 4'h6), 0, 2'b00, 32'hC0DE_0000);
        for (int i = 0; i < 5; i++) do_update(mk_ip(tags[2], 3, 4'h6), 1, 2'b00, 32'hC0DE_0000);
        do_update(mk_ip(tags[2], 3, 4'h6), 0, 2'b00, 32'hC0DE_0000);
        do_fetch(mk_ip(tags[2], 3, 4'h0), "R11 R9 counter held at 3");
        // R11: saturation low
        for (int i = 0; i < 5; i++) do_update(mk_ip(tags[2], 3, 4'h6), 0, 2'b00, 32'hC0DE_0000);
        do_update(mk_ip(tags[2], 3, 4'h6), 1, 2'b00, 32'hC0DE_0000);
        do_update(mk_ip(tags[2], 3, 4'h6), 1, 2'b00, 32'hC0DE_0000);
        do_update(mk_ip(tags[2], 3, 4'h6), 0, 2'b00, 32'hC0DE_0000);
        do_fetch(mk_ip(tags[2], 3, 4'h0), "R11 R9 counter held at 0");
        do_fetch(mk_ip(tags[2], 3, 4'h0), "R8 R9 history after shift");

        // R10: round robin, fifth allocation evicts the first
        for (int i = 0; i < 5; i++)
            do_update(mk_ip(21'h100 + 21'(i), 64, 4'h1), 1, 2'b10, 32'h4000_0000 + 32'(i));
        do_fetch(mk_ip(21'h100, 64, 4'h0), "R10 first way replaced");
        do_fetch(mk_ip(21'h104, 64, 4'h0), "R10 newest entry present");
        do_fetch(mk_ip(21'h101, 64, 4'h0), "R10 second entry kept");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ip = mk_ip(tags[$urandom_range(2)], sets[$urandom_range(3)], 4'($urandom_range(15)));
            if ($urandom_range(2) == 0) begin
                logic [1:0] kd = ($urandom_range(3) == 0) ? 2'($urandom_range(3)) : 2'b00;
                do_update(ip, 1'($urandom_range(1)) | (kd != 0), kd, $urandom);
            end else begin
                do_fetch(ip, "R2 R4 R5 R6 R7 R8 R9 R10 R11 random");
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule